// File: doc/BRIEF.md
# Extended State Restore Sequencer

This block plans the restore of a processor's extended register state from a save area. It takes four 64-bit inputs: an instruction mask, an enabled-feature register, and two bitmaps from the save-area header. One header bitmap marks which components hold saved data. The other describes compaction. From these the block works out, for each state component, whether to load it, initialize it or leave it alone. It also gives the byte offset to load from.

Data movement, memory access and the per-component offset and size tables sit outside the block. The block names the component it is working on through a lookup port. The table answers in the same cycle with that component's offset in the standard layout and its size.

Components are visited in ascending order, one per clock, from index 0 to index 62. A descriptor strobe appears only for components that need action. Component 1 carries a separate strobe pair for the control/status word.

The in-use and modified tracking bitmaps are updated together when the pass ends. The state machine has three states:
- **IDLE** leaves on an accepted start (IDLE→WALK).
- **WALK** steps one index per cycle and leaves after index 62 (WALK→FINISH).
- **FINISH** raises done for one cycle and always returns (FINISH→IDLE).

Top module: `xstate_restore_seq`

## Requirements
- R1: The requested mask is the bitwise AND of `instr_mask` and `feat_en`. A component whose requested bit is 0 produces no descriptor strobe and keeps its in-use bit.
- R2: Bit 63 of `compact_bm` selects the layout: 0 standard, 1 compacted. `layout_compact` shows the latched choice for the whole pass.
- R3: In the standard layout, a requested component with its present bit set gets `desc_act` = 1 (load). A requested component with its present bit clear gets `desc_act` = 2 (init). The value 0 (skip) never appears with `desc_valid`.
- R4: In the compacted layout, the format mask is `compact_bm` with bit 63 cleared. A component is loaded only when it is requested, formatted and present. A requested component that is not formatted, or not present, is initialized, even when its present bit is set.
- R5: In the compacted layout, the running offset starts at 576. It grows by `lk_size` after every formatted component of index 2 or more, whether or not that component is loaded. A loaded component of index 2 or more gets the running value as it stood before its own size was added.
- R6: In both layouts, components 0 and 1 use offsets 0 and 160. In the standard layout, components of index 2 or more take `lk_off`. `desc_off` is 0 for an init descriptor.
- R7: In the standard layout, `csw_load` pulses in the component-1 cycle whenever requested bit 1 or requested bit 2 is set, even if component 1 itself is skipped. `csw_init` never pulses in this layout.
- R8: In the compacted layout, `csw_load` pulses in the component-1 cycle when component 1 is loaded. `csw_init` pulses there when it is initialized, with `csw_init_val` = 0x1F80.
- R9: At the end of a pass, a loaded component's in-use bit becomes 1 and an initialized one becomes 0; others, and bit 63, are unchanged. `modified_bm` becomes the bitwise NOT of the requested mask. Both bitmaps take their new values at the clock edge that ends the done cycle.
- R10: A start seen in IDLE latches all four inputs. Index k is presented k+1 cycles after the start edge. `done` is high for exactly one cycle, 64 cycles after the start edge. A start while busy is ignored.
- R11: After reset the block is idle, with no strobes and both tracking bitmaps at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| instr_mask | input | 64 | Instruction mask |
| feat_en | input | 64 | Enabled-feature register |
| present_bm | input | 64 | Header bitmap of components holding saved data |
| compact_bm | input | 64 | Header compaction bitmap, bit 63 = layout select |
| lk_idx | output | 6 | Component index sent to the offset/size table |
| lk_off | input | 16 | Standard-layout offset of component `lk_idx` |
| lk_size | input | 16 | Size of component `lk_idx` |
| desc_valid | output | 1 | Descriptor strobe (load or init) |
| desc_idx | output | 6 | Component index of the descriptor |
| desc_act | output | 2 | 1 = load, 2 = init |
| desc_off | output | 16 | Byte offset for a load, 0 for init |
| csw_load | output | 1 | Load the control/status word from the save area |
| csw_init | output | 1 | Set the control/status word to its initial value |
| csw_init_val | output | 16 | Initial control/status value, valid with `csw_init` |
| layout_compact | output | 1 | Latched layout select of the current pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| inuse_bm | output | 64 | In-use tracking bitmap |
| modified_bm | output | 64 | Modified tracking bitmap |

## Verification
The bench builds the block at its defaults: 64-bit masks, 16-bit offsets, a legacy offset of 160, a compacted base of 576 and an initial control word of 0x1F80. At these values the full 63-component walk and the real bit-63 layout select are exercised.

The bench's table gives components sizes that differ by index. A wrongly advanced or wrongly skipped running offset therefore shows up in every later compacted offset. Two of the directed cases reach corners: standard-layout requests of component 2 without component 1, and compacted passes where components are present but not formatted.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
    typedef enum logic [1:0] {
        ACT_SKIP = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INIT = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/xrs_mask_calc.sv
module xrs_mask_calc #(
    parameter int MASK_W = 64
) (
    input  logic [MASK_W-1:0] instr_q,
    input  logic [MASK_W-1:0] feat_q,
    input  logic [MASK_W-1:0] pres_q,
    input  logic [MASK_W-1:0] comp_q,
    output logic [MASK_W-1:0] req,
    output logic [MASK_W-1:0] fmt,
    output logic              compact,
    output logic [MASK_W-1:0] load_m,
    output logic [MASK_W-1:0] init_m
);
    localparam int LAYOUT_BIT = MASK_W - 1;
    localparam logic [MASK_W-1:0] WALK_MASK = {1'b0, {(MASK_W-1){1'b1}}};

    always_comb begin
        req     = instr_q & feat_q;
        compact = comp_q[LAYOUT_BIT];
        fmt     = comp_q & WALK_MASK;
    end

    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        if (b == LAYOUT_BIT) begin : g_top
            assign load_m[b] = 1'b0;
            assign init_m[b] = 1'b0;
        end else begin : g_walk
            always_comb begin
                if (compact) begin
                    load_m[b] = req[b] & fmt[b] & pres_q[b];
                    init_m[b] = req[b] & ~(fmt[b] & pres_q[b]);
                end else begin
                    load_m[b] = req[b] & pres_q[b];
                    init_m[b] = req[b] & ~pres_q[b];
                end
            end
        end
    end

    always_comb begin
        a_r4_load_init_disjoint: assert ((load_m & init_m) == '0);
    end
endmodule

// File: rtl/xrs_offset_gen.sv
module xrs_offset_gen #(
    parameter int OFF_W        = 16,
    parameter int IDX_W        = 6,
    parameter int LEG_SSE_OFF  = 160,
    parameter int COMPACT_BASE = 576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             compact,
    input  logic             fmt_bit,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] lk_off,
    input  logic [OFF_W-1:0] lk_size,
    output logic [OFF_W-1:0] cur_off
);
    logic [OFF_W-1:0] run_off;
    logic             upper_idx;

    assign upper_idx = (idx > IDX_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_off <= OFF_W'(COMPACT_BASE);
        end else if (clear) begin
            run_off <= OFF_W'(COMPACT_BASE);
        end else if (step && compact && fmt_bit && upper_idx) begin
            run_off <= run_off + lk_size;
        end
    end

    always_comb begin
        if (idx == '0) begin
            cur_off = '0;
        end else if (idx == IDX_W'(1)) begin
            cur_off = OFF_W'(LEG_SSE_OFF);
        end else if (compact) begin
            cur_off = run_off;
        end else begin
            cur_off = lk_off;
        end
    end

    a_r5_base_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> run_off == OFF_W'(COMPACT_BASE));
    a_r5_hold_unformatted: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !fmt_bit) |=> $stable(run_off));
endmodule

// File: rtl/xrs_track.sv
module xrs_track #(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [MASK_W-1:0] req,
    input  logic [MASK_W-1:0] load_m,
    input  logic [MASK_W-1:0] init_m,
    output logic [MASK_W-1:0] inuse,
    output logic [MASK_W-1:0] modified
);
    logic [MASK_W-1:0] inuse_nxt;

    assign inuse_nxt = (inuse & ~(load_m | init_m)) | load_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inuse    <= '0;
            modified <= '0;
        end else if (commit) begin
            inuse    <= inuse_nxt;
            modified <= ~req;
        end
    end

    a_r9_modified_not_req: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> modified == ~$past(req));
    a_r9_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (inuse & $past(load_m)) == $past(load_m));
    a_r9_init_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (inuse & $past(init_m)) == '0);
    a_r9_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(inuse));
endmodule

// File: rtl/xstate_restore_seq.sv
module xstate_restore_seq
    import xrs_pkg::*;
#(
    parameter int MASK_W       = 64,
    parameter int OFF_W        = 16,
    parameter int CSW_W        = 16,
    parameter int LEG_SSE_OFF  = 160,
    parameter int COMPACT_BASE = 576,
    parameter int CSW_INIT     = 32'h1F80,
    localparam int IDX_W       = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MASK_W-1:0] instr_mask,
    input  logic [MASK_W-1:0] feat_en,
    input  logic [MASK_W-1:0] present_bm,
    input  logic [MASK_W-1:0] compact_bm,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [OFF_W-1:0]  lk_off,
    input  logic [OFF_W-1:0]  lk_size,
    output logic              desc_valid,
    output logic [IDX_W-1:0]  desc_idx,
    output logic [1:0]        desc_act,
    output logic [OFF_W-1:0]  desc_off,
    output logic              csw_load,
    output logic              csw_init,
    output logic [CSW_W-1:0]  csw_init_val,
    output logic              layout_compact,
    output logic              busy,
    output logic              done,
    output logic [MASK_W-1:0] inuse_bm,
    output logic [MASK_W-1:0] modified_bm
);
    localparam int LAST_IDX = MASK_W - 2;
    localparam logic [IDX_W-1:0] SSE_IDX = IDX_W'(1);
    localparam logic [IDX_W-1:0] VEC_IDX = IDX_W'(2);

    seq_state_e        state_q, state_nxt;
    logic [IDX_W-1:0]  idx_q;
    logic [MASK_W-1:0] instr_q, feat_q, pres_q, comp_q;
    logic [MASK_W-1:0] req, fmt, load_m, init_m;
    logic              compact;
    logic              accept, walking, last_step;
    logic [OFF_W-1:0]  cur_off;
    act_e              cur_act;

    assign accept    = (state_q == ST_IDLE) && start;
    assign walking   = (state_q == ST_WALK);
    assign last_step = (idx_q == IDX_W'(LAST_IDX));

    // state register, index counter and input latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            instr_q <= '0;
            feat_q  <= '0;
            pres_q  <= '0;
            comp_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                idx_q   <= '0;
                instr_q <= instr_mask;
                feat_q  <= feat_en;
                pres_q  <= present_bm;
                comp_q  <= compact_bm;
            end else if (walking && !last_step) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nxt = ST_WALK;
            ST_WALK:   if (last_step) state_nxt = ST_FINISH;
            ST_FINISH: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    xrs_mask_calc #(.MASK_W(MASK_W)) u_mask (
        .instr_q (instr_q),
        .feat_q  (feat_q),
        .pres_q  (pres_q),
        .comp_q  (comp_q),
        .req     (req),
        .fmt     (fmt),
        .compact (compact),
        .load_m  (load_m),
        .init_m  (init_m)
    );

    xrs_offset_gen #(
        .OFF_W        (OFF_W),
        .IDX_W        (IDX_W),
        .LEG_SSE_OFF  (LEG_SSE_OFF),
        .COMPACT_BASE (COMPACT_BASE)
    ) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (walking),
        .compact (compact),
        .fmt_bit (fmt[idx_q]),
        .idx     (idx_q),
        .lk_off  (lk_off),
        .lk_size (lk_size),
        .cur_off (cur_off)
    );

    xrs_track #(.MASK_W(MASK_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (state_q == ST_FINISH),
        .req      (req),
        .load_m   (load_m),
        .init_m   (init_m),
        .inuse    (inuse_bm),
        .modified (modified_bm)
    );

    always_comb begin
        if (load_m[idx_q])      cur_act = ACT_LOAD;
        else if (init_m[idx_q]) cur_act = ACT_INIT;
        else                    cur_act = ACT_SKIP;
    end

    // outputs
    always_comb begin
        desc_valid     = 1'b0;
        desc_act       = ACT_SKIP;
        desc_off       = '0;
        csw_load       = 1'b0;
        csw_init       = 1'b0;
        csw_init_val   = '0;
        busy           = 1'b0;
        done           = 1'b0;
        layout_compact = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WALK: begin
                busy           = 1'b1;
                layout_compact = compact;
                desc_valid     = (cur_act != ACT_SKIP);
                desc_act       = cur_act;
                desc_off       = (cur_act == ACT_LOAD) ? cur_off : '0;
                if (idx_q == SSE_IDX) begin
                    if (compact) begin
                        csw_load = (cur_act == ACT_LOAD);
                        csw_init = (cur_act == ACT_INIT);
                    end else begin
                        csw_load = req[SSE_IDX] | req[VEC_IDX];
                    end
                end
                if (csw_init) csw_init_val = CSW_W'(CSW_INIT);
            end
            ST_FINISH: begin
                busy           = 1'b1;
                done           = 1'b1;
                layout_compact = compact;
            end
            default: ;
        endcase
    end

    assign lk_idx   = idx_q;
    assign desc_idx = idx_q;

    a_r3_no_skip_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_act == ACT_LOAD || desc_act == ACT_INIT));
    a_r10_strobe_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid || csw_load || csw_init) |-> busy);
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    a_r10_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (walking && $past(walking)) |-> idx_q == $past(idx_q) + IDX_W'(1));
    a_r8_csw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(csw_load && csw_init));
    a_r7_std_no_csw_init: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !layout_compact) |-> !csw_init);
endmodule

// File: tb/xstate_restore_seq_test.sv
module xstate_restore_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] instr_mask = '0, feat_en = '0, present_bm = '0, compact_bm = '0;
    logic [5:0]  lk_idx;
    logic [15:0] lk_off, lk_size;
    logic        desc_valid, csw_load, csw_init, layout_compact, busy, done;
    logic [5:0]  desc_idx;
    logic [1:0]  desc_act;
    logic [15:0] desc_off, csw_init_val;
    logic [63:0] inuse_bm, modified_bm;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    // table model: standard offset and per-index size
    assign lk_off  = 16'd640 + 16'(lk_idx) * 16'd64;
    assign lk_size = 16'd16 * (16'(lk_idx % 6'd3) + 16'd1);

    xstate_restore_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .instr_mask(instr_mask), .feat_en(feat_en),
        .present_bm(present_bm), .compact_bm(compact_bm),
        .lk_idx(lk_idx), .lk_off(lk_off), .lk_size(lk_size),
        .desc_valid(desc_valid), .desc_idx(desc_idx), .desc_act(desc_act),
        .desc_off(desc_off), .csw_load(csw_load), .csw_init(csw_init),
        .csw_init_val(csw_init_val), .layout_compact(layout_compact),
        .busy(busy), .done(done), .inuse_bm(inuse_bm), .modified_bm(modified_bm)
    );

    // expected values
    logic [1:0]  exp_act [0:62];
    logic [15:0] exp_off [0:62];
    logic        exp_cswl, exp_cswi, exp_lay;
    logic [63:0] exp_inuse = '0, exp_mod = '0;

    // observed values
    logic [1:0]  seen_act [0:62];
    logic [15:0] seen_off [0:62];
    int          seen_cyc [0:62];
    int          cyc, done_cnt, done_cyc, cswl_cnt, cswl_cyc, cswi_cnt, cswi_cyc, lay_bad;
    logic [15:0] cswi_val;
    logic        collecting = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [63:0] ins, feat, pres, comp);
        logic [63:0] req, fmt;
        logic [15:0] run;
        req = ins & feat;
        fmt = comp & ~(64'd1 << 63);
        exp_lay = comp[63];
        run = 16'd576;
        for (int i = 0; i < 63; i++) begin
            bit ld, it;
            if (exp_lay) begin
                ld = req[i] && fmt[i] && pres[i];
                it = req[i] && !ld;
            end else begin
                ld = req[i] && pres[i];
                it = req[i] && !pres[i];
            end
            exp_act[i] = ld ? 2'd1 : (it ? 2'd2 : 2'd0);
            if (!ld) exp_off[i] = 16'd0;
            else if (i == 0) exp_off[i] = 16'd0;
            else if (i == 1) exp_off[i] = 16'd160;
            else if (exp_lay) exp_off[i] = run;
            else exp_off[i] = 16'd640 + 16'(i) * 16'd64;
            if (exp_lay && i >= 2 && fmt[i]) run = run + 16'd16 * (16'(i % 3) + 16'd1);
            if (ld) exp_inuse[i] = 1'b1;
            if (it) exp_inuse[i] = 1'b0;
        end
        exp_mod = ~req;
        if (exp_lay) begin
            exp_cswl = (exp_act[1] == 2'd1);
            exp_cswi = (exp_act[1] == 2'd2);
        end else begin
            exp_cswl = req[1] | req[2];
            exp_cswi = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (collecting) begin
            cyc++;
            if (desc_valid && desc_idx < 6'd63) begin
                seen_act[desc_idx] = desc_act;
                seen_off[desc_idx] = desc_off;
                seen_cyc[desc_idx] = cyc;
            end
            if (csw_load) begin cswl_cnt++; cswl_cyc = cyc; end
            if (csw_init) begin cswi_cnt++; cswi_cyc = cyc; cswi_val = csw_init_val; end
            if (busy && layout_compact != exp_lay) lay_bad++;
            if (done) begin done_cnt++; done_cyc = cyc; end
        end
    end

    task automatic run_op(input string name, input logic [63:0] ins, feat, pres, comp,
                          input bit inject);
        model(ins, feat, pres, comp);
        for (int i = 0; i < 63; i++) begin
            seen_act[i] = 2'd0; seen_off[i] = 16'd0; seen_cyc[i] = 0;
        end
        done_cnt = 0; done_cyc = 0; cswl_cnt = 0; cswl_cyc = 0;
        cswi_cnt = 0; cswi_cyc = 0; cswi_val = 0; lay_bad = 0;
        @(posedge clk); #1;
        instr_mask = ins; feat_en = feat; present_bm = pres; compact_bm = comp;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 0;
        collecting = 1'b1;
        if (inject) begin
            // R10: a second start mid-pass with different inputs must change nothing
            repeat (10) @(posedge clk);
            #1;
            instr_mask = ~ins; present_bm = ~pres; compact_bm = ~comp; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            repeat (70) @(posedge clk);
        end else begin
            repeat (80) @(posedge clk);
        end
        #1;
        collecting = 1'b0;
        for (int i = 0; i < 63; i++) begin
            chk(seen_act[i] == exp_act[i], $sformatf("R3/R4 %s act[%0d]", name, i),
                longint'(seen_act[i]), longint'(exp_act[i]));
            if (exp_act[i] != 2'd0) begin
                chk(seen_off[i] == exp_off[i], $sformatf("R5/R6 %s off[%0d]", name, i),
                    longint'(seen_off[i]), longint'(exp_off[i]));
                chk(seen_cyc[i] == i + 1, $sformatf("R10 %s cycle of idx %0d", name, i),
                    longint'(seen_cyc[i]), longint'(i + 1));
            end
        end
        chk(done_cnt == 1, {"R10 ", name, " done count"}, longint'(done_cnt), 1);
        chk(done_cyc == 64, {"R10 ", name, " done cycle"}, longint'(done_cyc), 64);
        chk(lay_bad == 0, {"R2 ", name, " layout flag"}, longint'(lay_bad), 0);
        chk(cswl_cnt == int'(exp_cswl), {"R7/R8 ", name, " csw load"}, longint'(cswl_cnt), longint'(exp_cswl));
        chk(cswi_cnt == int'(exp_cswi), {"R7/R8 ", name, " csw init"}, longint'(cswi_cnt), longint'(exp_cswi));
        if (exp_cswl) chk(cswl_cyc == 2, {"R7 ", name, " csw load cycle"}, longint'(cswl_cyc), 2);
        if (exp_cswi) chk(cswi_val == 16'h1F80, {"R8 ", name, " csw init value"}, longint'(cswi_val), 64'h1F80);
        chk(inuse_bm == exp_inuse, {"R9 ", name, " in-use"}, longint'(inuse_bm), longint'(exp_inuse));
        chk(modified_bm == exp_mod, {"R9 ", name, " modified"}, longint'(modified_bm), longint'(exp_mod));
    endtask

    task automatic t_reset();
        chk(!busy && !done && !desc_valid && !csw_load && !csw_init, "R11 idle strobes",
            longint'({busy, done, desc_valid, csw_load, csw_init}), 0);
        chk(inuse_bm == '0, "R11 in-use reset", longint'(inuse_bm), 0);
        chk(modified_bm == '0, "R11 modified reset", longint'(modified_bm), 0);
    endtask

    // R1 R3 R6: features mask off instruction bits, mixed present bits
    task automatic t_std_mixed();
        run_op("std_mixed", 64'hFFFF_0000_0000_00F7, 64'h0000_0000_0000_0FFF,
               64'h0000_0000_0000_00A5, 64'h0, 1'b0);
    endtask

    // R7: component 2 requested without component 1
    task automatic t_std_csw_only();
        run_op("std_csw", 64'h4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0);
        chk(seen_act[1] == 2'd0, "R7 comp1 untouched", longint'(seen_act[1]), 0);
    endtask

    // R4 R5: gaps in the format mask, present-but-unformatted forced to init
    task automatic t_cmp_gaps();
        run_op("cmp_gaps", 64'h0000_0000_0000_0FFF, 64'h0000_0000_FFFF_FFFF,
               64'h0000_0000_0000_0E3F, 64'h8000_0000_0000_0A17, 1'b0);
    endtask

    // R8: compacted, component 1 initialized
    task automatic t_cmp_init1();
        run_op("cmp_init1", 64'h7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4,
               64'h8000_0000_0000_0006, 1'b0);
    endtask

    // R10: start while busy is ignored
    task automatic t_busy_start();
        run_op("busy_start", 64'h0000_0000_0000_30C3, 64'hFFFF_FFFF_FFFF_FFFF,
               64'h0000_0000_0000_1043, 64'h0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_std_mixed();
        t_std_csw_only();
        t_cmp_gaps();
        t_cmp_init1();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule